// File: doc/BRIEF.md
# Two-Pass Sub-Ranging Conversion Sequencer

This block sets the timing of a sampling converter that digitises each sample in two passes through one flash quantiser. A qualified falling edge on the active-low trigger input puts the sample/hold into hold. After a programmable latch delay the block strobes a coarse capture. The coarse code is held and drives the reference DAC, and the pass-select line moves the quantiser input to the amplified residue. After a programmable settling interval the block strobes the fine capture, releases the sample/hold and merges the two codes into the output word. One cycle later it raises a single-cycle transfer pulse.

Every interval is a count of clock cycles, so one build covers fast and slow speed grades. The coarse and fine codes overlap by the number of bits that the two code widths exceed the output width. The merged word saturates at all-ones when the overlap carries out of the top bit. The output register only changes at the end of a conversion. Until then it holds the previous result, so data read after trigger N belong to conversion N-1.

Top module: `subr_conv_seq`

## Requirements
- R1: While `rst` is high and in the cycle after it, `hold`, `pass_sel`, `coarse_stb`, `fine_stb`, `xfer` and `busy_err` are 0, and `data_out` and `dac_code` are 0.
- R2: A conversion starts only after `trig_n` has been sampled high and then sampled low on MIN_LOW consecutive rising edges. `hold` rises after the edge that follows the MIN_LOW-th low sample. A shorter low pulse starts nothing, and a trigger that stays low does not start a second conversion.
- R3: `coarse_stb` is high for exactly one cycle, LATCH_DLY cycles after `hold` rises, while `pass_sel` is 0. At the end of that cycle `coarse_code` is captured onto `dac_code` and `pass_sel` goes to 1. `dac_code` does not change at any other time.
- R4: `fine_stb` is high for exactly one cycle, SETTLE_CYC cycles after `pass_sel` rises, while `pass_sel` and `hold` are both 1.
- R5: `hold` and `pass_sel` both fall at the edge that ends the `fine_stb` cycle.
- R6: At that same edge `data_out` becomes (`dac_code` << (OUT_W-COARSE_W)) + `fine_code`, saturated to all-ones on overflow when SATURATE=1. `data_out` changes at no other edge, so it shows the previous conversion until then.
- R7: `xfer` is a one-cycle pulse in the cycle after `data_out` is updated.
- R8: A qualified trigger that arrives while a conversion is in progress does not alter that conversion and does not start a new one. It sets `busy_err`, which stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running sequencer clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_n | input | 1 | Active-low conversion trigger |
| coarse_code | input | COARSE_W | Quantiser output during the coarse pass |
| fine_code | input | FINE_W | Quantiser output during the fine pass |
| hold | output | 1 | 1 = sample/hold in hold mode |
| coarse_stb | output | 1 | Coarse-pass capture strobe |
| pass_sel | output | 1 | 0 = quantiser sees attenuated input, 1 = residue |
| dac_code | output | COARSE_W | Held coarse code driving the reference DAC |
| fine_stb | output | 1 | Fine-pass capture strobe |
| xfer | output | 1 | One-cycle new-data pulse |
| data_out | output | OUT_W | Merged result of the last finished conversion |
| busy_err | output | 1 | Sticky flag: trigger seen during a conversion |

## Verification
The hardest state to reach is a second, fully qualified trigger that lands inside the settling window of a running conversion. To get there, the bench releases the first trigger as soon as `hold` rises. It then drives a fresh low pulse of MIN_LOW cycles while `pass_sel` is high, so the rejected start coincides with the fine-pass wait. The bench confirms that this conversion's timing and result are unchanged, that no extra conversion follows, and that the error flag latches. Changing the code inputs right after each strobe shows that captures happen only at the strobe edges.

// File: rtl/subr_pkg.sv
package subr_pkg;
   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_COARSE = 2'd1,
      ST_SETTLE = 2'd2,
      ST_XFER   = 2'd3
   } seq_state_e;
endpackage

// File: rtl/subr_trig_qual.sv
module subr_trig_qual #(
   parameter int MIN_LOW = 13
) (
   input  logic clk,
   input  logic rst,
   input  logic trig_n,
   output logic start
);
   localparam int CW = $clog2(MIN_LOW + 1);
   localparam logic [CW-1:0] LAST = CW'(MIN_LOW - 1);

   logic          armed;
   logic [CW-1:0] low_cnt;

   generate
      if (MIN_LOW < 1) begin : g_bad_min_low
         $error("MIN_LOW must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         armed   <= 1'b0;
         low_cnt <= '0;
         start   <= 1'b0;
      end else begin
         start <= 1'b0;
         if (trig_n) begin
            armed   <= 1'b1;
            low_cnt <= '0;
         end else if (armed) begin
            if (low_cnt == LAST) begin
               start   <= 1'b1;
               armed   <= 1'b0;
               low_cnt <= '0;
            end else begin
               low_cnt <= low_cnt + 1'b1;
            end
         end
      end
   end

   // R2
   start_single_chk: assert property (@(posedge clk) disable iff (rst)
      start |=> !start);
   // R2
   start_low_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(start) |-> $past(!trig_n));
endmodule

// File: rtl/subr_timer_fsm.sv
module subr_timer_fsm
   import subr_pkg::*;
#(
   parameter int LATCH_DLY  = 5,
   parameter int SETTLE_CYC = 60
) (
   input  logic clk,
   input  logic rst,
   input  logic start,
   output logic hold,
   output logic pass_sel,
   output logic coarse_stb,
   output logic fine_stb,
   output logic xfer,
   output logic busy_err
);
   localparam int MAXD  = (LATCH_DLY > SETTLE_CYC) ? LATCH_DLY : SETTLE_CYC;
   localparam int CNT_W = $clog2(MAXD + 1);
   localparam logic [CNT_W-1:0] C_LAST = CNT_W'(LATCH_DLY - 1);
   localparam logic [CNT_W-1:0] S_LAST = CNT_W'(SETTLE_CYC - 1);

   seq_state_e       state;
   logic [CNT_W-1:0] cnt;

   generate
      if (LATCH_DLY < 1 || SETTLE_CYC < 1) begin : g_bad_delay
         $error("LATCH_DLY and SETTLE_CYC must be at least 1");
      end
   endgenerate

   assign coarse_stb = (state == ST_COARSE) && (cnt == C_LAST);
   assign fine_stb   = (state == ST_SETTLE) && (cnt == S_LAST);

   always_ff @(posedge clk) begin
      if (rst) begin
         state    <= ST_IDLE;
         cnt      <= '0;
         hold     <= 1'b0;
         pass_sel <= 1'b0;
         xfer     <= 1'b0;
         busy_err <= 1'b0;
      end else begin
         xfer <= 1'b0;
         if (start && state != ST_IDLE) busy_err <= 1'b1;
         case (state)
            ST_IDLE: begin
               if (start) begin
                  state <= ST_COARSE;
                  cnt   <= '0;
                  hold  <= 1'b1;
               end
            end
            ST_COARSE: begin
               if (coarse_stb) begin
                  state    <= ST_SETTLE;
                  cnt      <= '0;
                  pass_sel <= 1'b1;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_SETTLE: begin
               if (fine_stb) begin
                  state    <= ST_XFER;
                  cnt      <= '0;
                  hold     <= 1'b0;
                  pass_sel <= 1'b0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            default: begin
               xfer  <= 1'b1;
               state <= ST_IDLE;
            end
         endcase
      end
   end

   // R3
   coarse_in_hold_chk: assert property (@(posedge clk) disable iff (rst)
      coarse_stb |-> (hold && !pass_sel));
   // R4
   pass_needs_hold_chk: assert property (@(posedge clk) disable iff (rst)
      pass_sel |-> hold);
   // R5
   release_after_fine_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(hold) |-> $past(fine_stb));
   // R7
   xfer_single_chk: assert property (@(posedge clk) disable iff (rst)
      xfer |=> !xfer);
   // R8
   busy_sticky_chk: assert property (@(posedge clk) disable iff (rst)
      busy_err |=> busy_err);
endmodule

// File: rtl/subr_result.sv
module subr_result #(
   parameter int COARSE_W = 9,
   parameter int FINE_W   = 9,
   parameter int OUT_W    = 16,
   parameter bit SATURATE = 1'b1
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                cap_coarse,
   input  logic                cap_fine,
   input  logic [COARSE_W-1:0] coarse_code,
   input  logic [FINE_W-1:0]   fine_code,
   output logic [COARSE_W-1:0] dac_code,
   output logic [OUT_W-1:0]    data_out
);
   localparam int SHIFT = OUT_W - COARSE_W;
   localparam int SUM_W = OUT_W + 1;

   logic [SUM_W-1:0] sum;
   logic [OUT_W-1:0] merged;

   generate
      if (COARSE_W > OUT_W || FINE_W > OUT_W) begin : g_bad_width
         $error("code widths must not exceed OUT_W");
      end
   endgenerate

   assign sum = (SUM_W'(dac_code) << SHIFT) + SUM_W'(fine_code);

   generate
      if (SATURATE) begin : g_sat
         assign merged = sum[OUT_W] ? '1 : sum[OUT_W-1:0];
      end else begin : g_wrap
         assign merged = sum[OUT_W-1:0];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         dac_code <= '0;
         data_out <= '0;
      end else begin
         if (cap_coarse) dac_code <= coarse_code;
         if (cap_fine)   data_out <= merged;
      end
   end

   // R3
   dac_only_on_coarse_chk: assert property (@(posedge clk) disable iff (rst)
      !$stable(dac_code) |-> $past(cap_coarse));
   // R6
   data_only_on_fine_chk: assert property (@(posedge clk) disable iff (rst)
      !$stable(data_out) |-> $past(cap_fine));
endmodule

// File: rtl/subr_conv_seq.sv
module subr_conv_seq #(
   parameter int COARSE_W   = 9,
   parameter int FINE_W     = 9,
   parameter int OUT_W      = 16,
   parameter int MIN_LOW    = 13,
   parameter int LATCH_DLY  = 5,
   parameter int SETTLE_CYC = 60,
   parameter bit SATURATE   = 1'b1
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                trig_n,
   input  logic [COARSE_W-1:0] coarse_code,
   input  logic [FINE_W-1:0]   fine_code,
   output logic                hold,
   output logic                coarse_stb,
   output logic                pass_sel,
   output logic [COARSE_W-1:0] dac_code,
   output logic                fine_stb,
   output logic                xfer,
   output logic [OUT_W-1:0]    data_out,
   output logic                busy_err
);
   logic start;

   subr_trig_qual #(.MIN_LOW(MIN_LOW)) i_qual (
      .clk    (clk),
      .rst    (rst),
      .trig_n (trig_n),
      .start  (start)
   );

   subr_timer_fsm #(.LATCH_DLY(LATCH_DLY), .SETTLE_CYC(SETTLE_CYC)) i_fsm (
      .clk        (clk),
      .rst        (rst),
      .start      (start),
      .hold       (hold),
      .pass_sel   (pass_sel),
      .coarse_stb (coarse_stb),
      .fine_stb   (fine_stb),
      .xfer       (xfer),
      .busy_err   (busy_err)
   );

   subr_result #(
      .COARSE_W (COARSE_W),
      .FINE_W   (FINE_W),
      .OUT_W    (OUT_W),
      .SATURATE (SATURATE)
   ) i_res (
      .clk         (clk),
      .rst         (rst),
      .cap_coarse  (coarse_stb),
      .cap_fine    (fine_stb),
      .coarse_code (coarse_code),
      .fine_code   (fine_code),
      .dac_code    (dac_code),
      .data_out    (data_out)
   );

   // R4
   fine_in_residue_chk: assert property (@(posedge clk) disable iff (rst)
      fine_stb |-> (pass_sel && hold));
   // R7
   xfer_after_data_chk: assert property (@(posedge clk) disable iff (rst)
      xfer |-> $past(!hold));
endmodule

// File: tb/test_subr_conv_seq.sv
module test_subr_conv_seq;
   localparam int CW = 9;
   localparam int FW = 9;
   localparam int OW = 16;
   localparam int ML = 3;
   localparam int LD = 4;
   localparam int SC = 10;

   typedef struct packed {
      logic [CW-1:0] c;
      logic [FW-1:0] f;
      logic [OW-1:0] r;
   } vec_t;

   // R6: result = coarse*128 + fine, saturated to 16'hFFFF
   localparam vec_t VEC [8] = '{
      '{9'h000, 9'h000, 16'd0},
      '{9'h001, 9'h000, 16'd128},
      '{9'h000, 9'h005, 16'd5},
      '{9'h100, 9'h040, 16'd32832},
      '{9'h1FF, 9'h07F, 16'd65535},
      '{9'h1FF, 9'h080, 16'd65535},
      '{9'h0AB, 9'h1FF, 16'd22399},
      '{9'h123, 9'h155, 16'd37589}
   };

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic trig_n = 1'b1;
   logic [CW-1:0] coarse_code = '0;
   logic [FW-1:0] fine_code = '0;
   logic hold, coarse_stb, pass_sel, fine_stb, xfer, busy_err;
   logic [CW-1:0] dac_code;
   logic [OW-1:0] data_out;

   int  n_chk = 0;
   int  n_fail = 0;
   bit  done = 1'b0;

   always #4 clk = ~clk;

   subr_conv_seq #(
      .COARSE_W(CW), .FINE_W(FW), .OUT_W(OW),
      .MIN_LOW(ML), .LATCH_DLY(LD), .SETTLE_CYC(SC), .SATURATE(1'b1)
   ) i_subr_conv_seq (
      .clk(clk), .rst(rst), .trig_n(trig_n),
      .coarse_code(coarse_code), .fine_code(fine_code),
      .hold(hold), .coarse_stb(coarse_stb), .pass_sel(pass_sel),
      .dac_code(dac_code), .fine_stb(fine_stb), .xfer(xfer),
      .data_out(data_out), .busy_err(busy_err)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic conv(input logic [CW-1:0] c, input logic [FW-1:0] f,
                       input logic [OW-1:0] exp, input logic [OW-1:0] prev,
                       input bit inject, input bit keep_low);
      trig_n = 1'b0;
      coarse_code = c;
      fine_code = f;
      tick(ML);
      check("R2 hold low before qualification", hold, 0);
      tick(1);
      check("R2 hold rises", hold, 1);
      check("R3 pass_sel low in coarse pass", pass_sel, 0);
      if (!keep_low) trig_n = 1'b1;
      tick(LD - 1);
      check("R3 coarse_stb", coarse_stb, 1);
      check("R3 pass_sel low at coarse strobe", pass_sel, 0);
      tick(1);
      check("R3 pass_sel rises", pass_sel, 1);
      check("R3 coarse_stb single", coarse_stb, 0);
      check("R3 dac_code captured", dac_code, c);
      coarse_code = ~c;
      for (int i = 0; i < SC - 1; i++) begin
         if (inject && i == 0) trig_n = 1'b0;
         if (inject && i == ML + 2) trig_n = 1'b1;
         check("R4 no early fine_stb", fine_stb, 0);
         tick(1);
      end
      check("R4 fine_stb", fine_stb, 1);
      check("R4 pass_sel at fine", pass_sel, 1);
      check("R4 hold at fine", hold, 1);
      check("R6 previous result held", data_out, prev);
      tick(1);
      fine_code = ~f;
      check("R5 hold released", hold, 0);
      check("R5 pass_sel released", pass_sel, 0);
      check("R6 merged result", data_out, exp);
      check("R7 xfer not yet", xfer, 0);
      check("R3 dac_code stable", dac_code, c);
      tick(1);
      check("R7 xfer pulse", xfer, 1);
      check("R6 result stable", data_out, exp);
      tick(1);
      check("R7 xfer single", xfer, 0);
   endtask

   task automatic summary;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      logic [OW-1:0] prev;
      tick(3);
      check("R1 hold", hold, 0);
      check("R1 pass_sel", pass_sel, 0);
      check("R1 strobes", {coarse_stb, fine_stb}, 0);
      check("R1 xfer", xfer, 0);
      check("R1 data_out", data_out, 0);
      check("R1 dac_code", dac_code, 0);
      check("R1 busy_err", busy_err, 0);
      rst = 1'b0;
      tick(2);
      check("R1 idle after reset", hold, 0);

      prev = '0;
      foreach (VEC[k]) begin
         conv(VEC[k].c, VEC[k].f, VEC[k].r, prev, 1'b0, 1'b0);
         prev = VEC[k].r;
         tick(2);
      end

      // R2: pulse one cycle too short
      trig_n = 1'b0;
      tick(ML - 1);
      trig_n = 1'b1;
      for (int i = 0; i < LD + SC + 4; i++) begin
         check("R2 short pulse ignored", hold, 0);
         tick(1);
      end
      check("R2 data unchanged after short pulse", data_out, prev);

      // R2: trigger held low starts only one conversion
      conv(9'h002, 9'h003, 16'd259, prev, 1'b0, 1'b1);
      prev = 16'd259;
      for (int i = 0; i < ML + 5; i++) begin
         check("R2 held low no retrigger", hold, 0);
         tick(1);
      end
      trig_n = 1'b1;
      tick(2);

      // R8: qualified trigger during settling
      check("R8 busy_err clear", busy_err, 0);
      conv(9'h055, 9'h011, 16'd10897, prev, 1'b1, 1'b0);
      check("R8 busy_err set", busy_err, 1);
      for (int i = 0; i < ML + LD + SC + 4; i++) begin
         check("R8 rejected trigger starts nothing", hold, 0);
         tick(1);
      end
      check("R8 busy_err sticky", busy_err, 1);
      check("R8 data unchanged", data_out, 16'd10897);

      rst = 1'b1;
      tick(2);
      rst = 1'b0;
      tick(1);
      check("R8 busy_err cleared by reset", busy_err, 0);
      check("R1 data cleared by reset", data_out, 0);
      conv(9'h001, 9'h000, 16'd128, 16'd0, 1'b0, 1'b0);

      done = 1'b1;
      summary();
      $finish;
   end
endmodule